// File: doc/BRIEF.md
# Cartridge Bank Latch with Diode Key Check

This block models a small discrete-logic cartridge register. Any CPU write that lands in the upper half of the CPU address space stores a full byte. Two low bits of that byte drive the character ROM bank lines. Two further bits stand in for a diode network used as copy protection. The character ROM is switched on only while those four bits match a key that is fixed per cartridge and given to the block as a 4-bit code.

The key code packs the bits as follows. Code bit 0 and code bit 1 are stored bits 0 and 1, the bank number. Code bit 2 is stored bit 4 and code bit 3 is stored bit 5, the diode bits. Bits of the stored byte that the key does not cover have no effect.

A 2-bit mode input decides whether a write suffers a bus conflict. In that case the stored value is the CPU byte ANDed with the ROM byte that answers the same address. When the character ROM is off, a read returns open-bus, which is modelled as all ones.

Top module: `cart_diode_latch`

## Requirements
- R1: After reset the stored byte is 0. The bank bits of `chr_addr` are then 0, and `chr_en` is high only when `key_code` is 0.
- R2: A cycle with `cpu_wr` high and `cpu_a15` high stores a byte, which is visible from the next cycle on.
- R3: A cycle with `cpu_wr` high and `cpu_a15` low leaves the stored byte unchanged.
- R4: With `conflict_mode` = 2, a write stores `cpu_data & rom_data`.
- R5: With `conflict_mode` = 0, 1 or 3, a write stores `cpu_data` unchanged.
- R6: `chr_en` is high exactly when stored bits {5,4,1,0} equal `key_code` bits {3,2,1,0}, taken in that order.
- R7: `chr_addr` is {stored bit 1, stored bit 0, `ppu_addr[12:0]`}, so the bank number occupies the two most significant bits.
- R8: `chr_data` equals `chr_rom_data` while `chr_en` is high, and equals 8'hFF while `chr_en` is low.
- R9: Stored bits 2, 3, 6 and 7 affect neither `chr_en` nor `chr_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_code | input | 4 | Expected diode and bank pattern |
| conflict_mode | input | 2 | 2 = apply bus conflict; any other value = no conflict |
| cpu_wr | input | 1 | CPU write strobe, one cycle |
| cpu_a15 | input | 1 | CPU address bit 15 |
| cpu_data | input | 8 | CPU write data |
| rom_data | input | 8 | ROM byte driven at the written address |
| ppu_addr | input | 13 | PPU character read address |
| chr_rom_data | input | 8 | Byte returned by the character ROM |
| chr_addr | output | 15 | Banked character ROM address |
| chr_en | output | 1 | Character ROM enabled |
| chr_data | output | 8 | Read data seen by the PPU |

## Verification
The hard case is a stored byte whose key bits match while its don't-care bits hold arbitrary values. Under a bus conflict, such a byte has to arise from the AND of two operands. To reach it, the bench writes every one of the 256 byte values under each of the 16 key codes and checks the enable and the bank for each pair. It then runs conflict sweeps in which the CPU byte and the ROM byte each hide bits that the other clears, so the key appears only after the AND.

// File: rtl/cart_latch_pkg.sv
package cart_latch_pkg;
  localparam int DATA_W  = 8;
  localparam int KEY_W   = 4;
  localparam int BANK_W  = 2;
  localparam logic [1:0] MODE_CONFLICT = 2'd2;

  // Gather the four key-relevant bits of a stored byte into code order.
  function automatic logic [KEY_W-1:0] key_of(input logic [DATA_W-1:0] v);
    return {v[5], v[4], v[1], v[0]};
  endfunction

  // Value that reaches the register for one write.
  function automatic logic [DATA_W-1:0] merge_write(input logic [1:0] mode,
                                                    input logic [DATA_W-1:0] cpu,
                                                    input logic [DATA_W-1:0] rom);
    return (mode == MODE_CONFLICT) ? (cpu & rom) : cpu;
  endfunction
endpackage

// File: rtl/cart_write_decode.sv
module cart_write_decode (
  input  logic cpu_wr,
  input  logic cpu_a15,
  output logic wr_hit
);
  assign wr_hit = cpu_wr & cpu_a15;
endmodule

// File: rtl/cart_store.sv
module cart_store
  import cart_latch_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [1:0]   conflict_mode,
  input  logic [W-1:0] cpu_data,
  input  logic [W-1:0] rom_data,
  output logic [W-1:0] latch_q
);
  logic [W-1:0] next_val;
  assign next_val = merge_write(conflict_mode, cpu_data, rom_data);

  always_ff @(posedge clk) begin
    if (!rst_n)      latch_q <= '0;
    else if (wr_hit) latch_q <= next_val;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> latch_q == '0);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(latch_q));
  assert_conflict_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && conflict_mode == 2'd2) |=> latch_q == $past(cpu_data & rom_data));
  assert_plain_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && conflict_mode != 2'd2) |=> latch_q == $past(cpu_data));
endmodule

// File: rtl/cart_key_check.sv
module cart_key_check
  import cart_latch_pkg::*;
(
  input  logic [KEY_W-1:0] key_code,
  input  logic [KEY_W-1:0] stored_key,
  output logic             key_match
);
  assign key_match = (stored_key == key_code);
endmodule

// File: rtl/cart_chr_out.sv
module cart_chr_out #(
  parameter int W      = 8,
  parameter int AW     = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [BANK_W-1:0] bank,
  input  logic [AW-1:0]     ppu_addr,
  input  logic [W-1:0]      rom_byte,
  output logic [BANK_W+AW-1:0] chr_addr,
  output logic [W-1:0]      chr_data
);
  localparam logic [W-1:0] OPEN_BUS = '1;

  assign chr_addr = {bank, ppu_addr};
  assign chr_data = enable ? rom_byte : OPEN_BUS;

  assert_open_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> chr_data == OPEN_BUS);
  assert_low_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chr_addr[AW-1:0] == ppu_addr);
endmodule

// File: rtl/cart_diode_latch.sv
module cart_diode_latch
  import cart_latch_pkg::*;
#(
  parameter int PPU_AW = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [KEY_W-1:0]         key_code,
  input  logic [1:0]               conflict_mode,
  input  logic                     cpu_wr,
  input  logic                     cpu_a15,
  input  logic [DATA_W-1:0]        cpu_data,
  input  logic [DATA_W-1:0]        rom_data,
  input  logic [PPU_AW-1:0]        ppu_addr,
  input  logic [DATA_W-1:0]        chr_rom_data,
  output logic [BANK_W+PPU_AW-1:0] chr_addr,
  output logic                     chr_en,
  output logic [DATA_W-1:0]        chr_data
);
  logic              wr_hit;
  logic [DATA_W-1:0] latch_q;
  logic [KEY_W-1:0]  stored_key;

  cart_write_decode u_dec (.cpu_wr(cpu_wr), .cpu_a15(cpu_a15), .wr_hit(wr_hit));

  cart_store #(.W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .conflict_mode(conflict_mode),
    .cpu_data(cpu_data), .rom_data(rom_data), .latch_q(latch_q));

  assign stored_key = key_of(latch_q);

  cart_key_check u_key (.key_code(key_code), .stored_key(stored_key), .key_match(chr_en));

  cart_chr_out #(.W(DATA_W), .AW(PPU_AW), .BANK_W(BANK_W)) u_out (
    .clk(clk), .rst_n(rst_n), .enable(chr_en), .bank(latch_q[BANK_W-1:0]),
    .ppu_addr(ppu_addr), .rom_byte(chr_rom_data), .chr_addr(chr_addr),
    .chr_data(chr_data));

  assert_dontcare_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(key_code) && $stable(latch_q[5:4]) && $stable(latch_q[1:0])) |-> $stable(chr_en));
endmodule

// File: tb/cart_diode_latch_tb_top.sv
module cart_diode_latch_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  key_code = 0;
  logic [1:0]  conflict_mode = 1;
  logic        cpu_wr = 0, cpu_a15 = 0;
  logic [7:0]  cpu_data = 0, rom_data = 0, chr_rom_data = 8'h5A;
  logic [12:0] ppu_addr = 13'h0ABC;
  logic [14:0] chr_addr;
  logic        chr_en;
  logic [7:0]  chr_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cart_diode_latch dut_i (.clk(clk), .rst_n(rst_n), .key_code(key_code),
    .conflict_mode(conflict_mode), .cpu_wr(cpu_wr), .cpu_a15(cpu_a15),
    .cpu_data(cpu_data), .rom_data(rom_data), .ppu_addr(ppu_addr),
    .chr_rom_data(chr_rom_data), .chr_addr(chr_addr), .chr_en(chr_en),
    .chr_data(chr_data));

  function automatic logic [3:0] pattern(input logic [7:0] v);
    return 4'(((v & 8'h30) >> 2) + (v & 8'h03));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Write one byte; outputs are sampled one time unit after the following falling edge.
  task automatic wr(input logic a15, input logic [7:0] d, input logic [7:0] r);
    @(negedge clk);
    cpu_wr = 1; cpu_a15 = a15; cpu_data = d; rom_data = r;
    @(negedge clk);
    cpu_wr = 0; cpu_a15 = 0;
    #1;
  endtask

  // Compare outputs against the stored value the bench expects.
  task automatic expect_state(input string req, input logic [7:0] v);
    logic en_exp;
    en_exp = (pattern(v) == key_code);
    chk({req, " en"}, chr_en, en_exp);
    chk({req, " addr"}, chr_addr, {v[1:0], ppu_addr});
    chk({req, " data"}, chr_data, en_exp ? chr_rom_data : 8'hFF);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog");
    if (!done) begin
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state with key 0 and key 9
    chk("R1 en key0", chr_en, 1);
    chk("R1 bank", chr_addr[14:13], 0);
    key_code = 4'd9; #1;
    chk("R1 en key9", chr_en, 0);
    chk("R8 open bus at reset", chr_data, 8'hFF);
    @(negedge clk); rst_n = 1;

    // R2 R6 R7 R8 R9: every key against every stored byte, no conflict
    conflict_mode = 2'd1;
    for (int k = 0; k < 16; k++) begin
      key_code = 4'(k);
      for (int v = 0; v < 256; v++) begin
        ppu_addr = 13'(v * 37 + k);
        chr_rom_data = 8'(v ^ 8'hC3);
        wr(1'b1, 8'(v), 8'h00);
        expect_state("R2/R6/R7/R8/R9", 8'(v));
      end
    end

    // R3: writes with A15 low ignored
    key_code = 4'b1011;
    wr(1'b1, 8'h23, 8'h00);
    expect_state("R3 setup", 8'h23);
    for (int v = 0; v < 256; v += 17) begin
      wr(1'b0, 8'(v), 8'hFF);
      expect_state("R3 ignored", 8'h23);
    end

    // R4: conflict AND, key only appears after AND
    conflict_mode = 2'd2;
    for (int d = 0; d < 256; d += 5)
      for (int r = 0; r < 256; r += 7) begin
        wr(1'b1, 8'(d), 8'(r));
        expect_state("R4", 8'(d & r));
      end
    key_code = 4'b1111;
    wr(1'b1, 8'hF3, 8'h3F);
    expect_state("R4 key via AND", 8'h33);
    chk("R4 key en", chr_en, 1);

    // R5: modes 0 and 3 store data unchanged
    foreach (conflict_mode[i]) ;
    for (int m = 0; m < 4; m += 3) begin
      conflict_mode = 2'(m);
      for (int d = 0; d < 256; d += 11) begin
        wr(1'b1, 8'(d), 8'h00);
        expect_state("R5", 8'(d));
      end
    end

    // R1: reset again returns stored byte to 0
    key_code = 4'd0;
    wr(1'b1, 8'hFF, 8'h00);
    @(negedge clk); rst_n = 0;
    @(negedge clk); #1;
    expect_state("R1 re-reset", 8'h00);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule